// File: doc/BRIEF.md
# Writable Free-Running Tick Counter

This block keeps a status word that counts up by one on every 10 ms of elapsed time. A controller reads the word and uses any of its bits as a square-wave clock. Each bit has a 50% duty cycle, and bit n repeats every 20 ms × 2^n. A prescaler divides the system clock down to a one-cycle tick. The counter word advances on that tick.

Software may load any value, and counting carries on from it. The word returns to zero at reset and whenever the controller enters its run or test mode. That entry is signalled by a one-cycle pulse. A configuration input selects a byte-only legacy mode. In that mode only the low byte counts and the upper byte reads as zero. A bit-select input brings one chosen bit of the word out on its own pin.

Top module: `tick_word_counter`

## Requirements
- R1: With no load and no clear, `count_word` increases by exactly one every `CLKS_PER_TICK` clock cycles, which is 10 ms at the design clock rate.
- R2: While `legacy_en` is 1, only the low `LEGACY_W` bits count. The upper bits of `count_word` read as zero, and the upper bits of a loaded value are discarded. The low byte wraps from 0xFF to 0x00.
- R3: `count_word` is 0 after reset. It is also 0 in the cycle after a `mode_enter` pulse, and `mode_enter` overrides a simultaneous write.
- R4: A write (`wr_en` = 1) makes `count_word` equal `wr_data` in the following cycle. Counting then continues upward from that value.
- R5: `sel_bit` equals bit `bit_sel` of `count_word`, where index 0 is the least significant bit. Bit n therefore toggles every 2^n ticks.
- R6: A load or a clear restarts the prescaler. The next increment comes exactly `CLKS_PER_TICK` cycles after the load or clear.
- R7: If a write coincides with a tick, the written value is taken and that tick is lost.
- R8: In full mode the word wraps from 0xFFFF to 0x0000 on a tick.
- R9: `tick_o` is high for one cycle, in the cycle just before each increment slot. It is never high in the cycle after a load or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_enter | input | 1 | One-cycle pulse on entry to run or test mode; clears the word |
| legacy_en | input | 1 | 1 selects the byte-only legacy mode |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | WORD_W | Value to load |
| bit_sel | input | SEL_W | Index of the bit driven onto `sel_bit` |
| count_word | output | WORD_W | Current counter value |
| sel_bit | output | 1 | Selected clock bit |
| tick_o | output | 1 | Prescaler terminal pulse |

## Verification
The bench builds the block with `CLKS_PER_TICK` = 3 and keeps the default 16-bit word and 8-bit legacy byte. A short divider lets every tick phase be reached within a few cycles. Writes and mode entries can therefore be placed on the terminal cycle of the prescaler, and the high bits and both wrap points can be reached by loading values near the boundaries. The bit select is swept through all sixteen positions in rotation, so every tap is compared against the arithmetic expected word.

// File: rtl/tick_pkg.sv
package tick_pkg;

   typedef enum logic [1:0] {
      UPD_HOLD  = 2'd0,
      UPD_CLEAR = 2'd1,
      UPD_LOAD  = 2'd2,
      UPD_STEP  = 2'd3
   } upd_e;

   // Clear beats load, and load beats a tick.
   function automatic upd_e pick_update(input logic clr, input logic ld, input logic stp);
      if (clr)      return UPD_CLEAR;
      else if (ld)  return UPD_LOAD;
      else if (stp) return UPD_STEP;
      else          return UPD_HOLD;
   endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int CLKS_PER_TICK = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int            PW   = $clog2(CLKS_PER_TICK);
   localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

   generate
      if (CLKS_PER_TICK < 2) begin : g_bad_div
         $error("CLKS_PER_TICK must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          phase_q <= '0;
      else if (restart || phase_q == LAST) phase_q <= '0;
      else                                 phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);

   a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/tick_word_reg.sv
module tick_word_reg
   import tick_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int LEGACY_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [WORD_W-1:0] load_val,
   input  logic              step,
   input  logic              legacy,
   output logic [WORD_W-1:0] word_o
);
   localparam logic [WORD_W-1:0] FULL_MASK = {WORD_W{1'b1}};
   localparam logic [WORD_W-1:0] LOW_MASK  = FULL_MASK >> (WORD_W - LEGACY_W);

   generate
      if (LEGACY_W < 1 || LEGACY_W > WORD_W) begin : g_bad_legacy
         $error("LEGACY_W must lie between 1 and WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] act_mask;
   upd_e              upd;

   generate
      if (LEGACY_W == WORD_W) begin : g_no_legacy
         assign act_mask = FULL_MASK;
      end else begin : g_legacy
         assign act_mask = legacy ? LOW_MASK : FULL_MASK;
      end
   endgenerate

   assign upd = pick_update(clear, load, step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else begin
         unique case (upd)
            UPD_CLEAR: word_q <= '0;
            UPD_LOAD:  word_q <= load_val & act_mask;
            UPD_STEP:  word_q <= (word_q + 1'b1) & act_mask;
            default:   word_q <= word_q;
         endcase
      end
   end

   assign word_o = word_q & act_mask;

   a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> word_q == '0);

   // R4 and R7: a load is taken even when a step arrives in the same cycle
   a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear && !legacy) |=> word_q == $past(load_val));

   a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && !load && !legacy && word_q != FULL_MASK)
      |=> word_q == $past(word_q) + 1'b1);

   a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && !load && !legacy && word_q == FULL_MASK) |=> word_q == '0);

   a_r2_high_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy && (step || load) && !clear) |=> (word_q & ~LOW_MASK) == '0);

endmodule

// File: rtl/tick_bit_tap.sv
module tick_bit_tap #(
   parameter int WORD_W = 16,
   parameter int SEL_W  = 4
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SEL_W-1:0]  sel,
   output logic              bit_o
);
   generate
      if ((1 << SEL_W) < WORD_W) begin : g_bad_sel
         $error("SEL_W too narrow to address every bit");
      end else if ((1 << SEL_W) > WORD_W) begin : g_guarded
         assign bit_o = (int'(sel) < WORD_W) ? word[sel] : 1'b0;
      end else begin : g_direct
         assign bit_o = word[sel];
      end
   endgenerate
endmodule

// File: rtl/tick_word_counter.sv
module tick_word_counter #(
   parameter int CLKS_PER_TICK = 1_000_000,
   parameter int WORD_W        = 16,
   parameter int LEGACY_W      = 8,
   parameter int SEL_W         = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_enter,
   input  logic              legacy_en,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  bit_sel,
   output logic [WORD_W-1:0] count_word,
   output logic              sel_bit,
   output logic              tick_o
);
   logic restart;
   logic tick;

   assign restart = mode_enter | wr_en;

   tick_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   tick_word_reg #(.WORD_W(WORD_W), .LEGACY_W(LEGACY_W)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (mode_enter),
      .load     (wr_en),
      .load_val (wr_data),
      .step     (tick),
      .legacy   (legacy_en),
      .word_o   (count_word)
   );

   tick_bit_tap #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_tap (
      .word  (count_word),
      .sel   (bit_sel),
      .bit_o (sel_bit)
   );

   assign tick_o = tick;

   a_r6_quiet_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick_o);

   a_r3_mode_wins: assert property (@(posedge clk) disable iff (!rst_n)
      mode_enter |=> count_word == '0);

endmodule

// File: tb/tick_word_counter_tb_top.sv
module tick_word_counter_tb_top;
   localparam int N  = 3;
   localparam int W  = 16;
   localparam int LW = 8;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          mode_enter, legacy_en, wr_en;
   logic [W-1:0]  wr_data;
   logic [SW-1:0] bit_sel;
   logic [W-1:0]  count_word;
   logic          sel_bit, tick_o;

   int           checks = 0;
   int           errors = 0;
   logic [W-1:0] exp_w;
   int           ph;
   int           sel_rot = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   tick_word_counter #(.CLKS_PER_TICK(N), .WORD_W(W), .LEGACY_W(LW), .SEL_W(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .legacy_en(legacy_en),
      .wr_en(wr_en), .wr_data(wr_data), .bit_sel(bit_sel),
      .count_word(count_word), .sel_bit(sel_bit), .tick_o(tick_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [W-1:0] msk();
      return legacy_en ? 16'h00FF : 16'hFFFF;
   endfunction

   // One clock: the model follows the requirements, then the outputs are compared.
   task automatic cyc(input string req);
      chk(tick_o == (ph == N-1), "R9", 32'(tick_o), 32'(ph == N-1));
      @(posedge clk);
      if (mode_enter)     begin exp_w = '0;               ph = 0; end
      else if (wr_en)     begin exp_w = wr_data & msk();  ph = 0; end
      else if (ph == N-1) begin exp_w = (exp_w + 1'b1) & msk(); ph = 0; end
      else                ph++;
      @(negedge clk);
      mode_enter = 1'b0;
      wr_en      = 1'b0;
      bit_sel    = SW'(sel_rot);
      sel_rot++;
      #1;
      chk(count_word == (exp_w & msk()), req, 32'(count_word), 32'(exp_w & msk()));
      chk(sel_bit == exp_w[bit_sel], "R5", 32'(sel_bit), 32'(exp_w[bit_sel]));
   endtask

   task automatic run(input int n, input string req);
      for (int i = 0; i < n; i++) cyc(req);
   endtask

   task automatic align_tick();
      while (ph != N-1) cyc("R1");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mode_enter = 1'b0; legacy_en = 1'b0; wr_en = 1'b0;
      wr_data = '0; bit_sel = '0;
      exp_w = '0; ph = 0;
      repeat (3) @(negedge clk);
      #1;
      chk(count_word == 16'h0, "R3", 32'(count_word), 32'h0);
      chk(tick_o == 1'b0, "R9", 32'(tick_o), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      run(60, "R1");                        // count up from zero

      wr_en = 1'b1; wr_data = 16'h1234;     // plain load
      cyc("R4");
      run(3*N, "R6");                       // prescaler restarted by the load

      align_tick();                         // load on the terminal cycle
      wr_en = 1'b1; wr_data = 16'h0FF0;
      cyc("R7");
      run(2*N, "R7");

      mode_enter = 1'b1;                    // mode entry clears
      cyc("R3");
      run(N+1, "R6");
      run(5, "R1");
      mode_enter = 1'b1; wr_en = 1'b1; wr_data = 16'hBEEF;  // clear beats write
      cyc("R3");
      run(2*N, "R3");

      wr_en = 1'b1; wr_data = 16'hFFFC;     // full-width wrap
      cyc("R4");
      run(6*N, "R8");

      wr_en = 1'b1; wr_data = 16'h7FF8;     // carry into bit 15
      cyc("R4");
      run(12*N, "R5");

      legacy_en = 1'b1;                     // high byte hidden
      run(N+2, "R2");
      wr_en = 1'b1; wr_data = 16'hABFC;
      cyc("R2");
      run(8*N, "R2");                       // low byte wraps FF -> 00
      align_tick();
      wr_en = 1'b1; wr_data = 16'h12FE;
      cyc("R7");
      run(4*N, "R2");
      mode_enter = 1'b1;
      cyc("R3");
      run(2*N, "R2");

      legacy_en = 1'b0;
      wr_en = 1'b1; wr_data = 16'h0000;
      cyc("R4");
      run(300, "R5");                       // long stretch for the low taps

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule